// File: doc/BRIEF.md
# Sigma-Delta Result Readout Register

This block sits between a decimation filter and a 16-bit processor bus. Each time the filter offers a new result word, the block latches it. A read of the single result register returns a 16-bit slice of that word. Which slice is returned depends on three settings: the oversampling ratio, which sets how wide the result is; the coding mode (bipolar or unipolar); and an access flag that selects either the top window or the 16 least significant bits. A byte read always returns the lowest eight bits of the result.

An optional toggle mode inverts the access flag after every read of the result register. Software can then fetch the whole result with two back-to-back reads: first the high window, then the low 16 bits, or the other way round, depending on where the flag starts.

The result input is a valid/ready stream. `res_ready` is held high at all times, so the block never applies back-pressure. A result transfers on any clock edge where `res_valid` is high, and a newer result simply replaces the older one. Configuration writes and bus reads are plain strobes. Read data is registered and appears one cycle after the read strobe, qualified by `rd_valid`.

Top module: `sdres_readout`

## Requirements
- R1: After reset, the latched result, the access flag and the toggle-enable flag are zero, `rd_valid` is 0 and `rd_data` is 0.
- R2: `res_ready` is always 1. When `res_valid` is 1 at a clock edge, `res_data` is latched as the current result.
- R3: The ratio code `cfg_osr` (0..5) selects a result width W = 15 + 3*code, giving 15, 18, 21, 24, 27 and 30 bits. Codes 6 and 7 behave like code 5.
- R4: A word read with the access flag at 0 in bipolar mode (`cfg_unipolar`=0) returns result bits W-1 down to W-16, with bit W-1 in `rd_data[15]`.
- R5: A word read with the access flag at 0 in unipolar mode returns result bits W-2 down to W-17, with bit W-2 in `rd_data[15]`.
- R6: Result positions below bit 0 read as zero. At code 0 with the access flag at 0, `rd_data[0]` is zero in bipolar mode and `rd_data[1:0]` is zero in unipolar mode.
- R7: A word read (`rd_byte`=0) with the access flag at 1 returns result bits 15..0.
- R8: A byte read (`rd_byte`=1) returns result bits 7..0 in `rd_data[7:0]` with `rd_data[15:8]` zero, whatever the access flag, mode or ratio.
- R9: When toggle-enable is 1, every read (word or byte) inverts the access flag. The read itself uses the old flag value and the next read uses the new value.
- R10: Writing toggle-enable through `cfg_we` never changes the access flag. With toggle-enable at 0, reads leave the access flag unchanged.
- R11: If a read and a new result arrive in the same cycle, the read returns a slice of the previously latched result, and the new result is seen by later reads.
- R12: `rd_valid` is 1 exactly in the cycle after `rd_en` was 1. `rd_data` holds its value when there is no read.
- R13: `acc_we` loads `acc_val` into the access flag. If it coincides with a toggling read, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | Filter result offered |
| res_ready | output | 1 | Always 1; the block never stalls |
| res_data | input | 30 | Filter result word |
| cfg_we | input | 1 | Write strobe for ratio code, mode and toggle-enable |
| cfg_osr | input | 3 | Oversampling ratio code |
| cfg_unipolar | input | 1 | 1 = unipolar coding, 0 = bipolar |
| cfg_tog_en | input | 1 | Toggle-enable value |
| acc_we | input | 1 | Write strobe for the access flag |
| acc_val | input | 1 | Access flag value to write |
| rd_en | input | 1 | Read strobe for the result register |
| rd_byte | input | 1 | 1 = byte read, 0 = word read |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | `rd_data` updated by the previous cycle's read |

## Verification
Three functions can fall in the same clock cycle. A read can coincide with a new result strobe, and a toggling read can coincide with an explicit access-flag write or with a write of toggle-enable. The bench drives these combinations in a single cycle on purpose. A behavioural model decides what each should produce: the old result is read and the new one is captured, the explicit write beats the toggle, and the read uses the old toggle-enable. The model is compared with `rd_data` and `rd_valid` on every clock, and the reads that follow expose the access-flag state left behind.

// File: rtl/sdres_pkg.sv
package sdres_pkg;
  localparam int OSR_CODE_W = 3;
  localparam int OSR_CODE_MAX = 5;
  localparam int WIDTH_BASE = 15;
  localparam int WIDTH_STEP = 3;

  typedef struct packed {
    logic [OSR_CODE_W-1:0] osr;
    logic                  unipolar;
    logic                  tog_en;
  } sdres_cfg_t;

  function automatic int unsigned res_width(input logic [OSR_CODE_W-1:0] code);
    int unsigned c;
    c = (int'(code) > OSR_CODE_MAX) ? OSR_CODE_MAX : int'(code);
    return WIDTH_BASE + WIDTH_STEP * c;
  endfunction
endpackage

// File: rtl/sdres_capture.sv
module sdres_capture #(
  parameter int RES_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  output logic [RES_W-1:0] res_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)         res_q <= '0;
    else if (res_valid) res_q <= res_data;
  end

  // R2
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> res_q == $past(res_data));
  // R2
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(res_q));
endmodule

// File: rtl/sdres_window.sv
module sdres_window
  import sdres_pkg::*;
#(
  parameter int RES_W = 30,
  parameter int BUS_W = 16
) (
  input  logic [RES_W-1:0]      res_q,
  input  logic [OSR_CODE_W-1:0] osr,
  input  logic                  unipolar,
  input  logic                  acc_flag,
  output logic [BUS_W-1:0]      word_val,
  output logic [BUS_W-1:0]      byte_val
);
  localparam int PAD    = 2;
  localparam int EXT_W  = RES_W + PAD;
  localparam int SH_W   = $clog2(EXT_W + 1);
  localparam int HALF_W = BUS_W / 2;

  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] shifted;
  logic [SH_W-1:0]  shamt;
  int unsigned      top_pos;

  // The two pad bits below the result make negative positions read as zero.
  assign ext = {res_q, {PAD{1'b0}}};

  always_comb begin
    top_pos = res_width(osr) - 1 - (unipolar ? 1 : 0);
    shamt   = SH_W'(top_pos + PAD - (BUS_W - 1));
  end

  assign shifted  = ext >> shamt;
  assign word_val = acc_flag ? res_q[BUS_W-1:0] : shifted[BUS_W-1:0];
  assign byte_val = {{(BUS_W-HALF_W){1'b0}}, res_q[HALF_W-1:0]};
endmodule

// File: rtl/sdres_access.sv
module sdres_access #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             rd_byte,
  input  logic             acc_we,
  input  logic             acc_val,
  input  logic             tog_en,
  input  logic [BUS_W-1:0] word_val,
  input  logic [BUS_W-1:0] byte_val,
  output logic             acc_flag,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_valid
);
  localparam int HALF_W = BUS_W / 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_flag <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_byte ? byte_val : word_val;
      if (acc_we)                acc_flag <= acc_val;
      else if (rd_en && tog_en)  acc_flag <= ~acc_flag;
    end
  end

  // R9
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && tog_en && !acc_we) |=> acc_flag != $past(acc_flag));
  // R10
  flag_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tog_en && !acc_we) |=> $stable(acc_flag));
  // R13
  flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |=> acc_flag == $past(acc_val));
  // R12
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && $stable(rd_data)));
  // R8
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_byte) |=> rd_data[BUS_W-1:HALF_W] == '0);
endmodule

// File: rtl/sdres_readout.sv
module sdres_readout
  import sdres_pkg::*;
#(
  parameter int RES_W = 30,
  parameter int BUS_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  res_valid,
  output logic                  res_ready,
  input  logic [RES_W-1:0]      res_data,
  input  logic                  cfg_we,
  input  logic [OSR_CODE_W-1:0] cfg_osr,
  input  logic                  cfg_unipolar,
  input  logic                  cfg_tog_en,
  input  logic                  acc_we,
  input  logic                  acc_val,
  input  logic                  rd_en,
  input  logic                  rd_byte,
  output logic [BUS_W-1:0]      rd_data,
  output logic                  rd_valid
);
  sdres_cfg_t       cfg_q;
  logic [RES_W-1:0] res_q;
  logic [BUS_W-1:0] word_val;
  logic [BUS_W-1:0] byte_val;
  logic             acc_flag;

  assign res_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= '{osr: cfg_osr, unipolar: cfg_unipolar, tog_en: cfg_tog_en};
  end

  sdres_capture #(.RES_W(RES_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid),
    .res_data(res_data), .res_q(res_q)
  );

  sdres_window #(.RES_W(RES_W), .BUS_W(BUS_W)) win_i (
    .res_q(res_q), .osr(cfg_q.osr), .unipolar(cfg_q.unipolar),
    .acc_flag(acc_flag), .word_val(word_val), .byte_val(byte_val)
  );

  sdres_access #(.BUS_W(BUS_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_byte(rd_byte),
    .acc_we(acc_we), .acc_val(acc_val), .tog_en(cfg_q.tog_en),
    .word_val(word_val), .byte_val(byte_val), .acc_flag(acc_flag),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R2
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) res_ready);
  // R10
  cfg_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !rd_en && !acc_we) |=> $stable(acc_flag));
endmodule

// File: tb/sdres_readout_tb.sv
module sdres_readout_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic res_valid = 0, res_ready, cfg_we = 0, cfg_unipolar = 0, cfg_tog_en = 0;
  logic acc_we = 0, acc_val = 0, rd_en = 0, rd_byte = 0, rd_valid;
  logic [RW-1:0] res_data = '0;
  logic [2:0] cfg_osr = '0;
  logic [15:0] rd_data;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model state
  logic [RW-1:0] m_res;
  logic [2:0] m_osr;
  bit m_uni, m_tog, m_acc, m_valid;
  logic [15:0] m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdres_readout dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .cfg_we(cfg_we), .cfg_osr(cfg_osr),
    .cfg_unipolar(cfg_unipolar), .cfg_tog_en(cfg_tog_en), .acc_we(acc_we),
    .acc_val(acc_val), .rd_en(rd_en), .rd_byte(rd_byte), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  function automatic logic [15:0] model_slice(logic [RW-1:0] r, logic [2:0] osr,
                                             bit uni, bit acc, bit byt);
    int w, top, idx;
    logic [15:0] v;
    v = '0;
    if (byt) begin
      for (int i = 0; i < 8; i++) v[i] = r[i];
      return v;
    end
    if (acc) return r[15:0];
    w = (osr > 5) ? 30 : 15 + 3 * osr;
    top = uni ? w - 2 : w - 1;
    for (int i = 15; i >= 0; i--) begin
      idx = top - (15 - i);
      v[i] = (idx >= 0) ? r[idx] : 1'b0;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_res = '0; m_osr = '0; m_uni = 0; m_tog = 0; m_acc = 0;
      m_valid = 0; m_data = '0;
    end else begin
      m_valid = rd_en;
      if (rd_en) m_data = model_slice(m_res, m_osr, m_uni, m_acc, rd_byte);
      if (acc_we) m_acc = acc_val;
      else if (rd_en && m_tog) m_acc = !m_acc;
      if (res_valid) m_res = res_data;
      if (cfg_we) begin m_osr = cfg_osr; m_uni = cfg_unipolar; m_tog = cfg_tog_en; end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "rd_valid", 32'(rd_valid), 32'(m_valid));
      check(cur_req, "rd_data", 32'(rd_data), 32'(m_data));
      check("R2", "res_ready", 32'(res_ready), 32'd1);
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic idle();
    res_valid = 0; cfg_we = 0; acc_we = 0; rd_en = 0; rd_byte = 0;
  endtask
  task automatic load(logic [RW-1:0] v);
    res_valid = 1; res_data = v; tick(); idle();
  endtask
  task automatic cfg(logic [2:0] o, bit u, bit t);
    cfg_we = 1; cfg_osr = o; cfg_unipolar = u; cfg_tog_en = t; tick(); idle();
  endtask
  task automatic setacc(bit a); acc_we = 1; acc_val = a; tick(); idle(); endtask
  task automatic rd(bit b); rd_en = 1; rd_byte = b; tick(); idle(); endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    #2;
    // R1 reset state at the ports
    check("R1", "rd_valid after reset", 32'(rd_valid), 0);
    check("R1", "rd_data after reset", 32'(rd_data), 0);
    tick();
    cur_req = "R1"; rd(0); tick();

    cur_req = "R4";
    load(30'h2ABC_DEF1);
    for (int c = 0; c < 8; c++) begin
      cur_req = "R3"; cfg(3'(c), 0, 0); rd(0);
      cur_req = "R5"; cfg(3'(c), 1, 0); rd(0);
    end
    load(30'h1357_9BDF);
    for (int c = 0; c < 6; c++) begin
      cur_req = "R4"; cfg(3'(c), 0, 0); rd(0);
      cur_req = "R5"; cfg(3'(c), 1, 0); rd(0);
    end

    // R6 directed: ratio code 0, all ones in the 15-bit result
    cur_req = "R6";
    load(30'h0000_7FFF);
    cfg(0, 0, 0); rd(0); #2;
    check("R6", "bipolar code0 window", 32'(rd_data), 32'h0000_FFFE);
    cfg(0, 1, 0); rd(0); #2;
    check("R6", "unipolar code0 window", 32'(rd_data), 32'h0000_FFFC);

    cur_req = "R7";
    load(30'h3FED_CBA9);
    setacc(1); cfg(5, 0, 0); rd(0); #2;
    check("R7", "low word", 32'(rd_data), 32'h0000_CBA9);
    cfg(2, 1, 0); rd(0);

    cur_req = "R8";
    rd(1); #2;
    check("R8", "byte read acc1", 32'(rd_data), 32'h0000_00A9);
    setacc(0); cfg(4, 1, 0); rd(1); #2;
    check("R8", "byte read acc0", 32'(rd_data), 32'h0000_00A9);

    // R9 toggling pair: high window then low word
    cur_req = "R9";
    cfg(5, 0, 1); rd(0); #2;
    check("R9", "first read high", 32'(rd_data), 32'h0000_FFB7);
    rd(0); #2;
    check("R9", "second read low", 32'(rd_data), 32'h0000_CBA9);
    rd(1); rd(0); rd(0); rd(0);
    // back-to-back reads
    rd_en = 1; repeat (4) tick(); idle();

    // R10 toggle-enable written: flag stays where it was
    cur_req = "R10";
    cfg(5, 0, 0); setacc(1); cfg(5, 0, 1); cfg(5, 0, 0);
    rd(0); #2;
    check("R10", "flag kept at 1", 32'(rd_data), 32'h0000_CBA9);
    rd(0); rd(0);
    // cfg write coincides with a read: the read uses the old toggle-enable
    rd_en = 1; cfg_we = 1; cfg_osr = 5; cfg_tog_en = 1; cfg_unipolar = 0; tick(); idle();
    rd(0); rd(0);

    // R11 read and new result in the same cycle
    cur_req = "R11";
    cfg(5, 0, 0); setacc(1);
    rd_en = 1; res_valid = 1; res_data = 30'h0000_1234; tick(); idle(); #2;
    check("R11", "old result read", 32'(rd_data), 32'h0000_CBA9);
    rd(0); #2;
    check("R11", "new result next", 32'(rd_data), 32'h0000_1234);

    // R13 explicit write beats a toggling read
    cur_req = "R13";
    cfg(5, 0, 1); setacc(0);
    rd_en = 1; acc_we = 1; acc_val = 0; tick(); idle();
    rd(0); #2;
    check("R13", "written flag won", 32'(rd_data), 32'h0000_0000);
    rd(0); #2;
    check("R13", "toggled to low", 32'(rd_data), 32'h0000_1234);

    cur_req = "R12";
    repeat (3) tick();
    for (int k = 0; k < 40; k++) begin
      res_valid = k[0]; res_data = 30'(k * 32'h0135_79BD);
      rd_en = k[1] ^ k[3]; rd_byte = k[2];
      if (k % 7 == 0) begin cfg_we = 1; cfg_osr = 3'(k % 8); cfg_unipolar = k[1]; cfg_tog_en = k[4]; end
      tick(); idle();
    end
    repeat (2) tick();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule